// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by reading a three-level page table in memory, starting from a table base supplied on an input. Each request carries the virtual address, the access kind (read, write or execute), a privilege mode index and a physical-mode flag. The walker answers with the physical address, the granted permission bits, a success flag and a fault code.

Three kinds of request finish without touching memory. A physical-mode request passes its address straight through. A virtual address whose upper bits are not a sign extension is refused. A kernel-only direct-mapped window in the negative half of the space is relocated arithmetically. All other requests walk the tables. Each level issues one single-cycle read request and then waits for the returning data. The last entry supplies per-mode read and write enables and three fault-on-operation bits that can veto an otherwise allowed access.

The host keeps one request outstanding at a time. It presents a request while `req_ready` is high and takes the answer in the single cycle in which `rsp_valid` is high.

Top module: `ptw_walker`

## Requirements
- R1: A request with `req_phys`=1 completes with no memory read. `rsp_valid` rises in the cycle after acceptance, with `rsp_ok`=1, fault code 0, `rsp_paddr` equal to the virtual address and `rsp_prot`=3'b111. In `rsp_prot`, bit 0 is read, bit 1 is write and bit 2 is execute.
- R2: A virtual request whose bits [63:43] are not all equal completes with no memory read and fault code 1 (access violation). Bit 43 is the default implemented width.
- R3: A request with bit 63 set, bits [63:43] all equal and bits [42:41]=2'b10 uses the direct window. In mode 0 (kernel) it succeeds with no memory read and `rsp_prot`=3'b111. Its physical address keeps virtual bits [39:0], places virtual bit 40 at physical bit 43, and clears every other bit.
- R4: A direct-window request in any mode other than 0 completes with fault code 1 and no memory read.
- R5: The walk reads its three entries in order. The first is at `ptbr` + va[42:33]*8. The second is at base1 + va[32:23]*8. The third is at base2 + va[22:13]*8. Each base is the previous entry's bits [63:32] shifted left by 13.
- R6: At the first and second level, an entry with bit 0 (valid) clear ends the walk with fault code 2 (not valid). An entry with bit 0 set and bit 8 (kernel read enable) clear ends it with fault code 1. No further read follows either fault.
- R7: At the third level, bit 0 clear gives fault code 2. Otherwise the read and execute permissions come from bit 8+mode and the write permission from bit 12+mode. If the permission the access needs is absent, the fault code is 1. Kind 0 is read, kind 1 is write, and kinds 2 and 3 are execute.
- R8: Third-entry bits 1, 2 and 3 withdraw read, write and execute respectively. If the withdrawal leaves the needed permission absent, the fault code is 5 for execute, 4 for write and 3 for read.
- R9: A successful walk returns `rsp_ok`=1 and fault code 0. The physical address is the third entry's bits [63:32] shifted left by 13, ORed with va[12:0]. The permissions are the enabled set minus any withdrawn ones. Every fault returns `rsp_ok`=0 and `rsp_prot`=0.
- R10: `req_ready` is high only while idle. `mem_req` is a one-cycle pulse once per level, and `mem_addr` holds steady until the data returns. `rsp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual (or physical) address |
| req_kind | input | 2 | 0 read, 1 write, 2/3 execute |
| req_mode | input | 2 | Privilege mode index, 0 = kernel |
| req_phys | input | 1 | Physical-mode request |
| ptbr | input | 64 | First-level table base |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Entry address to read |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Answer valid for one cycle |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 3 | 0 none, 1 access, 2 not valid, 3 read, 4 write, 5 execute |
| rsp_paddr | output | 64 | Physical address |
| rsp_prot | output | 3 | Granted permissions {x,w,r} |

## Verification
On every cycle, the assertions check the handshake shape: single-cycle request and answer pulses, no acceptance while a read is outstanding, and a read address that holds steady while a level waits. They also check the one-cycle completion of physical-mode and non-canonical requests. Only the bench scenarios can show the arithmetic. That covers the entry addresses taken from each index field and the relocation of bit 40 in the direct window. It also covers the choice between the access, not-valid and fault-on codes for each entry pattern and mode, and the exact number of reads each outcome costs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1, ST_L2, ST_L3, ST_DONE
    } walk_st_e;

    localparam int BIT_VALID  = 0;
    localparam int BIT_RD_EN  = 8;
    localparam int BIT_WR_EN  = 12;
    localparam int WIN_LO_BIT = 41;
    localparam int WIN_MOVE   = 40;
    localparam int WIN_DEST   = 43;

    function automatic logic [2:0] need_of(input logic [1:0] kind);
        case (kind)
            2'd0:    need_of = 3'b001;
            2'd1:    need_of = 3'b010;
            default: need_of = 3'b100;
        endcase
    endfunction
endpackage

// File: rtl/ptw_classify.sv
module ptw_classify
    import ptw_pkg::*;
#(
    parameter int VA_BITS = 43
) (
    input  logic [63:0] vaddr,
    input  logic [1:0]  mode,
    input  logic        phys,
    output logic        early,
    output fault_e      fault,
    output logic [2:0]  prot,
    output logic [63:0] paddr
);
    localparam int HI_W = 64 - VA_BITS;

    logic [HI_W-1:0] hi;
    logic            canon;
    logic            window;

    always_comb begin
        hi     = vaddr[63:VA_BITS];
        canon  = (&hi) | ~(|hi);
        window = vaddr[63] && (vaddr[WIN_LO_BIT+1:WIN_LO_BIT] == 2'b10);
        early  = 1'b1;
        fault  = FLT_ACV;
        prot   = 3'b000;
        paddr  = '0;
        if (phys) begin
            fault = FLT_NONE;
            prot  = 3'b111;
            paddr = vaddr;
        end else if (!canon) begin
            fault = FLT_ACV;
        end else if (window) begin
            if (mode == 2'd0) begin
                fault = FLT_NONE;
                prot  = 3'b111;
                paddr = {24'b0, vaddr[WIN_MOVE-1:0]};
                paddr[WIN_DEST] = vaddr[WIN_MOVE];
            end
        end else begin
            early = 1'b0;
        end
    end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
    import ptw_pkg::*;
#(
    parameter int PAGE_BITS = 13
) (
    input  logic [63:0] pte,
    input  logic [63:0] vaddr,
    input  logic [1:0]  mode,
    input  logic [1:0]  kind,
    output fault_e      fault,
    output logic [2:0]  prot,
    output logic [63:0] paddr
);
    logic [2:0] need, granted, kept;
    logic       rd_en, wr_en;

    always_comb begin
        need    = need_of(kind);
        rd_en   = pte[BIT_RD_EN + 32'(mode)];
        wr_en   = pte[BIT_WR_EN + 32'(mode)];
        granted = {rd_en, wr_en, rd_en};
        kept    = granted & ~pte[3:1];
        paddr   = ({32'b0, pte[63:32]} << PAGE_BITS)
                | (vaddr & ((64'd1 << PAGE_BITS) - 64'd1));
        prot    = 3'b000;
        if (!pte[BIT_VALID]) begin
            fault = FLT_TNV;
        end else if ((granted & need) == 3'b000) begin
            fault = FLT_ACV;
        end else if ((kept & need) == 3'b000) begin
            fault = need[2] ? FLT_FOE : (need[1] ? FLT_FOW : FLT_FOR);
        end else begin
            fault = FLT_NONE;
            prot  = kept;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int VA_BITS   = 43,
    parameter int IDX_BITS  = 10,
    parameter int LEVELS    = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_mode,
    input  logic        req_phys,
    input  logic [63:0] ptbr,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_valid,
    input  logic [63:0] mem_data,
    output logic        rsp_valid,
    output logic        rsp_ok,
    output logic [2:0]  rsp_fault,
    output logic [63:0] rsp_paddr,
    output logic [2:0]  rsp_prot
);
    localparam int ENT_SHIFT = 3;

    typedef struct packed {
        walk_st_e    st;
        logic        issued;
        logic [63:0] va;
        logic [1:0]  kind;
        logic [1:0]  mode;
        logic [63:0] base;
        fault_e      fault;
        logic [2:0]  prot;
        logic [63:0] paddr;
    } walk_t;

    walk_t walk_d, walk_q;

    logic        cl_early;
    fault_e      cl_fault;
    logic [2:0]  cl_prot;
    logic [63:0] cl_paddr;
    fault_e      lf_fault;
    logic [2:0]  lf_prot;
    logic [63:0] lf_paddr;
    logic [63:0] ent_addr [LEVELS];
    logic [63:0] next_base;
    logic        in_walk;

    ptw_classify #(.VA_BITS(VA_BITS)) u_classify (
        .vaddr(req_vaddr), .mode(req_mode), .phys(req_phys),
        .early(cl_early), .fault(cl_fault), .prot(cl_prot), .paddr(cl_paddr)
    );

    ptw_leaf #(.PAGE_BITS(PAGE_BITS)) u_leaf (
        .pte(mem_data), .vaddr(walk_q.va), .mode(walk_q.mode), .kind(walk_q.kind),
        .fault(lf_fault), .prot(lf_prot), .paddr(lf_paddr)
    );

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam int LSB = PAGE_BITS + (LEVELS - 1 - g) * IDX_BITS;
        assign ent_addr[g] = walk_q.base
            + ({{(64-IDX_BITS){1'b0}}, walk_q.va[LSB +: IDX_BITS]} << ENT_SHIFT);
    end

    assign in_walk   = (walk_q.st == ST_L1) || (walk_q.st == ST_L2) || (walk_q.st == ST_L3);
    assign next_base = {32'b0, mem_data[63:32]} << PAGE_BITS;

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va     = req_vaddr;
                    walk_d.kind   = req_kind;
                    walk_d.mode   = req_mode;
                    walk_d.base   = ptbr;
                    walk_d.issued = 1'b0;
                    walk_d.fault  = cl_fault;
                    walk_d.prot   = cl_prot;
                    walk_d.paddr  = cl_paddr;
                    walk_d.st     = cl_early ? ST_DONE : ST_L1;
                end
            end
            ST_L1, ST_L2: begin
                if (!walk_q.issued) begin
                    walk_d.issued = 1'b1;
                end else if (mem_valid) begin
                    walk_d.issued = 1'b0;
                    walk_d.prot   = 3'b000;
                    if (!mem_data[BIT_VALID]) begin
                        walk_d.fault = FLT_TNV;
                        walk_d.st    = ST_DONE;
                    end else if (!mem_data[BIT_RD_EN]) begin
                        walk_d.fault = FLT_ACV;
                        walk_d.st    = ST_DONE;
                    end else begin
                        walk_d.base = next_base;
                        walk_d.st   = (walk_q.st == ST_L1) ? ST_L2 : ST_L3;
                    end
                end
            end
            ST_L3: begin
                if (!walk_q.issued) begin
                    walk_d.issued = 1'b1;
                end else if (mem_valid) begin
                    walk_d.issued = 1'b0;
                    walk_d.fault  = lf_fault;
                    walk_d.prot   = lf_prot;
                    walk_d.paddr  = lf_paddr;
                    walk_d.st     = ST_DONE;
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, issued: 1'b0, va: '0, kind: '0, mode: '0,
                        base: '0, fault: FLT_NONE, prot: '0, paddr: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        case (walk_q.st)
            ST_L2:   mem_addr = ent_addr[1];
            ST_L3:   mem_addr = ent_addr[2];
            default: mem_addr = ent_addr[0];
        endcase
    end

    assign req_ready = (walk_q.st == ST_IDLE);
    assign mem_req   = in_walk && !walk_q.issued;
    assign rsp_valid = (walk_q.st == ST_DONE);
    assign rsp_ok    = (walk_q.fault == FLT_NONE);
    assign rsp_fault = walk_q.fault;
    assign rsp_paddr = walk_q.paddr;
    assign rsp_prot  = walk_q.prot;

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_memreq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_walk && !mem_valid) |=> $stable(mem_addr));
    p_phys_fast_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_phys) |=> (rsp_valid && rsp_ok && rsp_prot == 3'b111));
    p_noncanon_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_phys
         && !((&req_vaddr[63:VA_BITS]) || !(|req_vaddr[63:VA_BITS])))
        |=> (rsp_valid && rsp_fault == 3'd1));
    p_ok_prot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (rsp_prot != 3'b000));
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_mode = '0;
    logic        req_phys = 1'b0;
    logic [63:0] ptbr = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_data = '0;
    logic        rsp_valid, rsp_ok;
    logic [2:0]  rsp_fault, rsp_prot;
    logic [63:0] rsp_paddr;

    int n_chk = 0, n_bad = 0, n_rd = 0;
    int unsigned cyc = 0;
    logic [63:0] rd_log [3];
    logic [63:0] mem [logic [63:0]];

    always #4 clk = ~clk;

    ptw_walker u_ptw_walker (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act %0d cycles exp <150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    initial begin : responder
        forever begin
            @(posedge clk);
            if (mem_req) begin
                if (n_rd < 3) rd_log[n_rd] = mem_addr;
                n_rd++;
                repeat ($urandom % 3) @(posedge clk);
                @(negedge clk);
                mem_valid = 1'b1;
                mem_data  = rd(mem_addr);
                @(negedge clk);
                mem_valid = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    // Independent model of the requirements
    function automatic void model(input logic [63:0] va, input logic [1:0] kind,
            input logic [1:0] mode, input logic ph, input logic [63:0] tb,
            output logic [2:0] f, output logic [2:0] p, output logic [63:0] pa,
            output int nr, output logic [63:0] ad [3]);
        logic [63:0] base, e;
        logic [2:0] need, g;
        logic r, w;
        f = 0; p = 0; pa = 0; nr = 0; base = tb;
        for (int i = 0; i < 3; i++) ad[i] = '0;
        need = (kind == 0) ? 3'b001 : (kind == 1) ? 3'b010 : 3'b100;
        if (ph) begin p = 3'b111; pa = va; return; end
        if (!(va[63:43] == '0 || va[63:43] == '1)) begin f = 1; return; end
        if (va[63] && va[42:41] == 2'b10) begin
            if (mode != 0) begin f = 1; return; end
            p = 3'b111;
            pa = (va & 64'hFF_FFFF_FFFF) | (64'(va[40]) << 43);
            return;
        end
        for (int lv = 0; lv < 3; lv++) begin
            ad[lv] = base + 64'(va[13 + 10*(2-lv) +: 10]) * 8;
            e = rd(ad[lv]);
            nr++;
            if (!e[0]) begin f = 2; return; end
            if (lv < 2) begin
                if (!e[8]) begin f = 1; return; end
                base = 64'(e[63:32]) << 13;
            end else begin
                r = e[8 + mode]; w = e[12 + mode];
                g = {r, w, r};
                if ((g & need) == 0) begin f = 1; return; end
                g = g & ~e[3:1];
                if ((g & need) == 0) begin
                    f = need[2] ? 3'd5 : need[1] ? 3'd4 : 3'd3;
                    return;
                end
                p = g;
                pa = (64'(e[63:32]) << 13) | 64'(va[12:0]);
            end
        end
    endfunction

    task automatic run(input string tag, input logic [63:0] va, input logic [1:0] kind,
                       input logic [1:0] mode, input logic ph, input logic [63:0] tb);
        logic [2:0] ef, ep; logic [63:0] epa; int enr; logic [63:0] ead [3];
        int wait_n;
        model(va, kind, mode, ph, tb, ef, ep, epa, enr, ead);
        n_rd = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_kind = kind; req_mode = mode;
        req_phys = ph; ptbr = tb;
        @(negedge clk);
        req_valid = 0;
        if (ph || enr == 0 && ef != 0 || (enr == 0 && ep == 3'b111))
            chk({tag, " R1/R2 one-cycle answer"}, 64'(rsp_valid), 64'd1);
        wait_n = 0;
        while (!rsp_valid && wait_n < 100) begin @(negedge clk); wait_n++; end
        chk({tag, " answer arrives R10"}, 64'(rsp_valid), 64'd1);
        chk({tag, " fault R6 R7 R8"}, 64'(rsp_fault), 64'(ef));
        chk({tag, " ok R9"}, 64'(rsp_ok), 64'(ef == 0));
        chk({tag, " prot R9"}, 64'(rsp_prot), 64'(ep));
        if (ef == 0) chk({tag, " paddr R3 R9"}, rsp_paddr, epa);
        chk({tag, " read count R5"}, 64'(n_rd), 64'(enr));
        for (int i = 0; i < 3; i++)
            if (i < enr && i < n_rd) chk({tag, " entry addr R5"}, rd_log[i], ead[i]);
        @(negedge clk);
        chk({tag, " single pulse R10"}, 64'(rsp_valid), 64'd0);
        chk({tag, " back to idle R10"}, 64'(req_ready), 64'd1);
    endtask

    // Install a full table path for va from tb with given entries
    task automatic build(input logic [63:0] va, input logic [63:0] tb,
                         input logic [63:0] e1, input logic [63:0] e2, input logic [63:0] e3);
        logic [63:0] a;
        a = tb + 64'(va[42:33]) * 8;                          mem[a] = e1;
        a = (64'(e1[63:32]) << 13) + 64'(va[32:23]) * 8;       mem[a] = e2;
        a = (64'(e2[63:32]) << 13) + 64'(va[22:13]) * 8;       mem[a] = e3;
    endtask

    function automatic logic [63:0] rnd_pte();
        logic [63:0] e;
        e[63:32] = $urandom & 32'h000F_FFFF;
        e[31:16] = '0;
        e[15:9]  = 7'($urandom);
        e[8]     = ($urandom % 8) != 0;
        e[7:4]   = '0;
        e[3]     = ($urandom % 4) == 0;
        e[2]     = ($urandom % 4) == 0;
        e[1]     = ($urandom % 4) == 0;
        e[0]     = ($urandom % 10) != 0;
        return e;
    endfunction

    localparam logic [63:0] TB0 = 64'h0000_0000_0004_0000;
    localparam logic [63:0] VA0 = 64'h0000_0123_4567_89AB;
    localparam logic [63:0] P1  = 64'h0000_0010_0000_0101;
    localparam logic [63:0] P2  = 64'h0000_0020_0000_0101;

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("reset idle R10", 64'(req_ready), 64'd1);
        chk("reset no answer R10", 64'(rsp_valid), 64'd0);
        chk("reset no read R10", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        run("phys R1", 64'hDEAD_BEEF_0000_1234, 2'd1, 2'd3, 1'b1, TB0);
        run("noncanon R2", 64'h0100_0000_0000_0000, 2'd0, 2'd0, 1'b0, TB0);
        run("window bit40 R3", 64'hFFFF_FD12_3456_789A, 2'd1, 2'd0, 1'b0, TB0);
        run("window user R4", 64'hFFFF_FC00_0000_1000, 2'd0, 2'd3, 1'b0, TB0);

        build(VA0, TB0, 64'h0, P2, 64'h0);
        run("L1 invalid R6", VA0, 2'd0, 2'd0, 1'b0, TB0);
        build(VA0, TB0, P1, 64'h0000_0020_0000_0001, 64'h0);
        run("L2 no kre R6", VA0, 2'd0, 2'd0, 1'b0, TB0);
        build(VA0, TB0, P1, P2, 64'h0000_0030_0000_1F00);
        run("L3 invalid R7", VA0, 2'd0, 2'd0, 1'b0, TB0);
        build(VA0, TB0, P1, P2, 64'h0000_0030_0000_0F01);
        run("L3 no write R7", VA0, 2'd1, 2'd2, 1'b0, TB0);
        build(VA0, TB0, P1, P2, 64'h0000_0030_0000_FF09);
        run("fault exec R8", VA0, 2'd2, 2'd1, 1'b0, TB0);
        build(VA0, TB0, P1, P2, 64'h0000_0030_0000_FF05);
        run("fault write R8", VA0, 2'd1, 2'd1, 1'b0, TB0);
        build(VA0, TB0, P1, P2, 64'h0000_0030_0000_FF03);
        run("fault read R8", VA0, 2'd0, 2'd3, 1'b0, TB0);
        build(VA0, TB0, P1, P2, 64'h0000_0030_0000_8801);
        run("user read ok R9", VA0, 2'd0, 2'd3, 1'b0, TB0);

        for (int t = 0; t < 400; t++) begin
            logic [63:0] va, tb;
            int sel;
            sel = $urandom % 8;
            tb  = 64'($urandom & 32'h000F_FFFF) << 13;
            if (sel == 0) va = {$urandom, $urandom};
            else if (sel == 1) va = {21'h1F_FFFF, 2'b10, 9'($urandom), $urandom};
            else begin
                va[42:0]  = {11'($urandom), $urandom};
                va[63:43] = {21{va[42]}};
            end
            build(va, tb, rnd_pte(), rnd_pte(), rnd_pte());
            run("random R5 R7 R8 R9", va, 2'($urandom % 4), 2'($urandom),
                ($urandom % 16) == 0, tb);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule